// File: doc/BRIEF.md
# Single-Place Four-Phase Push Buffer

This block holds one data word between a sender and a receiver that both talk in four-phase request/acknowledge form, with the data bundled alongside the request. The input side is passive: it waits for the sender to raise its request, copies the word into an internal register, and answers with an acknowledge. The output side is active: once the input exchange has returned to zero, the block places the stored word on its output and raises its own request, then waits for the receiver's acknowledge and its return to zero.

The block repeats a fixed input-then-output cycle forever. Because the word sits in a register of its own, the input exchange completes fully before the output exchange begins, so the two sides never hold each other's signals. Both sides are sampled on the same clock; a request or acknowledge is a level seen at a rising edge.

Back-pressure works like this. The sender holds its request and data until it sees the acknowledge, then drops the request and waits for the acknowledge to drop. The receiver holds off the output for as long as it leaves its acknowledge low; while the output exchange is open, a new input request stays unanswered, so the sender is stalled. The receiver must keep its acknowledge high until the output request falls.

Top module: `pb_push_buffer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `in_ack` and `out_req` are both 0.
- R2: With the buffer empty, a high `in_req` sampled at a rising edge stores `in_data` at that edge and makes `in_ack` 1 after that same edge.
- R3: `in_ack` stays 1 while `in_req` is sampled high, and falls at the first edge that samples `in_req` low.
- R4: At the edge where `in_ack` falls, `out_req` rises, with `out_data` already equal to the stored word; `out_data` does not change while `out_req` is 1.
- R5: `out_req` stays 1 while `out_ack` is sampled low, and falls at the first edge that samples `out_ack` high.
- R6: `in_ack` and `out_req` are never 1 in the same cycle.
- R7: After `out_req` falls, the block does not raise `in_ack` until an edge has sampled `out_ack` low; only at the next edge that samples `in_req` high does `in_ack` rise.
- R8: Under any sender and receiver delays, words leave in the order they entered, none lost and none repeated.
- R9: The data path width is the parameter `WIDTH`, 16 bits by default; every bit, including bit 0 and the top bit, passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all levels sampled at its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 1 | Sender's request; data valid while high |
| in_data | input | WIDTH | Sender's word, bundled with `in_req` |
| in_ack | output | 1 | Acknowledge to the sender: word taken |
| out_req | output | 1 | Request to the receiver: word valid |
| out_data | output | WIDTH | Stored word, bundled with `out_req` |
| out_ack | input | 1 | Receiver's acknowledge: word consumed |

## Verification
The assertions check each cycle that the two handshakes never overlap, that each acknowledge or request is held until its partner moves, that `in_ack` rises only after a request and never while the output side is busy, and that the output word is frozen while offered. Only the bench scenarios can show the exact cycle of each edge after a stimulus, the value carried through each bit, and that a long stream under swept and random sender and receiver delays arrives in order with no word lost or repeated.

// File: rtl/pb_pkg.sv
package pb_pkg;

  // Phases of the repeating input-then-output cycle.
  typedef enum logic [1:0] {
    PB_EMPTY = 2'd0,  // waiting for a sender request
    PB_TAKEN = 2'd1,  // word stored, input acknowledge high
    PB_OFFER = 2'd2,  // output request high, word on output
    PB_CLEAR = 2'd3   // waiting for receiver acknowledge to drop
  } pb_phase_e;

endpackage

// File: rtl/pb_seq.sv
module pb_seq
  import pb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_req,
  input  logic out_ack,
  output logic load,
  output logic in_ack,
  output logic out_req
);

  pb_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    load    = 1'b0;
    unique case (phase_q)
      PB_EMPTY: if (in_req) begin
        load    = 1'b1;
        phase_d = PB_TAKEN;
      end
      PB_TAKEN: if (!in_req)  phase_d = PB_OFFER;
      PB_OFFER: if (out_ack)  phase_d = PB_CLEAR;
      PB_CLEAR: if (!out_ack) phase_d = PB_EMPTY;
      default:                phase_d = PB_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PB_EMPTY;
    else        phase_q <= phase_d;
  end

  // Both handshake outputs come straight from the phase register.
  assign in_ack  = (phase_q == PB_TAKEN);
  assign out_req = (phase_q == PB_OFFER);

endmodule

// File: rtl/pb_hold.sv
module pb_hold #(
  parameter int WIDTH       = 16,
  parameter bit CLEAR_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  localparam logic [WIDTH-1:0] ZERO = '0;

  generate
    if (CLEAR_RESET) begin : g_clear
      always_ff @(posedge clk) begin
        if (!rst_n)    q <= ZERO;
        else if (load) q <= d;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (load) q <= d;
      end
    end
  endgenerate

endmodule

// File: rtl/pb_push_buffer.sv
module pb_push_buffer #(
  parameter int WIDTH       = 16,
  parameter bit CLEAR_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_req,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ack,
  output logic             out_req,
  output logic [WIDTH-1:0] out_data,
  input  logic             out_ack
);

  logic load;

  pb_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_req  (in_req),
    .out_ack (out_ack),
    .load    (load),
    .in_ack  (in_ack),
    .out_req (out_req)
  );

  pb_hold #(
    .WIDTH       (WIDTH),
    .CLEAR_RESET (CLEAR_RESET)
  ) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .d     (in_data),
    .q     (out_data)
  );

endmodule

// File: rtl/pb_push_buffer_chk.sv
module pb_push_buffer_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_req,
  input logic [WIDTH-1:0] in_data,
  input logic             in_ack,
  input logic             out_req,
  input logic [WIDTH-1:0] out_data,
  input logic             out_ack
);

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> $past(in_req)); // R2

  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack && in_req) |=> in_ack); // R3

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |-> $stable(out_data)); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !out_ack) |=> out_req); // R5

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ack && out_req)); // R6

  AST_NO_ACK_WHILE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> !$past(out_req)); // R7

endmodule

bind pb_push_buffer pb_push_buffer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_req   (in_req),
  .in_data  (in_data),
  .in_ack   (in_ack),
  .out_req  (out_req),
  .out_data (out_data),
  .out_ack  (out_ack)
);

// File: tb/tb_pb_push_buffer.sv
module tb_pb_push_buffer;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_req = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ack;
  logic         out_req;
  logic [W-1:0] out_data;
  logic         out_ack = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  // stream bookkeeping
  int n_sent = 0;
  int n_recv = 0;
  int order_bad = 0;
  int overlap_bad = 0;
  int stable_bad = 0;
  logic         prev_req = 1'b0;
  logic [W-1:0] prev_data = '0;

  always #5 clk = ~clk;

  pb_push_buffer #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_req(in_req), .in_data(in_data), .in_ack(in_ack),
    .out_req(out_req), .out_data(out_data), .out_ack(out_ack)
  );

  function automatic logic [W-1:0] word_of(int i);
    return W'(i * 32'h9E37 + 32'h1234) ^ W'(i << 11);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (in_ack && out_req) overlap_bad++;
      if (prev_req && out_req && out_data != prev_data) stable_bad++;
    end
    prev_req  = out_req;
    prev_data = out_data;
    if (cycles > 150000 && !done) begin
      check(1'b0, "watchdog", cycles, 150000);
      summary();
    end
  end

  task automatic tick(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Sender: one word per call, with a delay before the request.
  task automatic send(int i, int dly);
    tick(dly);
    in_data = word_of(i);
    in_req  = 1'b1;
    do @(negedge clk); while (!in_ack);
    in_req  = 1'b0;
    in_data = ~word_of(i);
    do @(negedge clk); while (in_ack);
    n_sent++;
  endtask

  // Receiver: one word per call, with a delay before the acknowledge.
  task automatic recv(int dly);
    while (!out_req) @(negedge clk);
    tick(dly);
    if (out_data !== word_of(n_recv)) begin
      order_bad++;
      $display("FAIL R8 actual=%0h expected=%0h", out_data, word_of(n_recv));
    end
    n_recv++;
    out_ack = 1'b1;
    do @(negedge clk); while (out_req);
    out_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic stream(int base, int cnt, int sd, int rd, bit rnd);
    fork
      for (int j = 0; j < cnt; j++) send(base + j, rnd ? int'($urandom_range(0, 4)) : sd);
      for (int j = 0; j < cnt; j++) recv(rnd ? int'($urandom_range(0, 4)) : rd);
    join
  endtask

  // Single word, fully stepped, checking the cycle of each edge.
  task automatic pass_one(logic [W-1:0] v, string req);
    in_data = v; in_req = 1'b1;
    @(negedge clk);
    check(in_ack == 1'b1, "R2", in_ack, 1);
    in_req = 1'b0; in_data = ~v;
    @(negedge clk);
    check(out_req == 1'b1 && out_data == v, req, out_data, v);
    out_ack = 1'b1;
    @(negedge clk);
    out_ack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    tick(3);
    check(in_ack == 1'b0 && out_req == 1'b0, "R1 in reset", {in_ack, out_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ack == 1'b0 && out_req == 1'b0, "R1 after reset", {in_ack, out_req}, 0);

    // Directed walk through one full cycle.
    in_data = 16'hA5C3; in_req = 1'b1;
    @(negedge clk);
    check(in_ack == 1'b1, "R2 ack one edge after req", in_ack, 1);
    in_data = 16'h0000;              // data may change once acknowledged
    tick(2);
    check(in_ack == 1'b1 && out_req == 1'b0, "R3 ack held", {in_ack, out_req}, 2);
    in_req = 1'b0;
    @(negedge clk);
    check(in_ack == 1'b0, "R3 ack drops", in_ack, 0);
    check(out_req == 1'b1, "R4 out_req rises with ack fall", out_req, 1);
    check(out_data == 16'hA5C3, "R4 stored word offered", out_data, 16'hA5C3);
    tick(3);
    check(out_req == 1'b1 && out_data == 16'hA5C3, "R5 req held without ack", out_data, 16'hA5C3);
    out_ack = 1'b1;
    @(negedge clk);
    check(out_req == 1'b0, "R5 req drops after ack", out_req, 0);
    in_data = 16'h3C5A; in_req = 1'b1; // new word while receiver still acknowledges
    tick(2);
    check(in_ack == 1'b0, "R7 no ack while out_ack high", in_ack, 0);
    out_ack = 1'b0;
    @(negedge clk);
    check(in_ack == 1'b0, "R7 no ack on the edge seeing out_ack low", in_ack, 0);
    @(negedge clk);
    check(in_ack == 1'b1, "R7 ack follows once empty", in_ack, 1);
    in_req = 1'b0;
    @(negedge clk);
    check(out_req == 1'b1 && out_data == 16'h3C5A, "R4 second word", out_data, 16'h3C5A);
    out_ack = 1'b1;
    @(negedge clk);
    out_ack = 1'b0;
    @(negedge clk);

    // R9: bit patterns over the full width.
    pass_one(16'h8000, "R9 top bit");
    pass_one(16'h0001, "R9 bit 0");
    pass_one(16'hFFFF, "R9 all ones");
    pass_one(16'h0000, "R9 all zeros");
    for (int b = 0; b < W; b++) pass_one(W'(1) << b, "R9 walking one");

    // R8: sweep of fixed sender/receiver delays, then random delays.
    for (int sd = 0; sd < 4; sd++)
      for (int rd = 0; rd < 4; rd++)
        stream(n_sent, 8, sd, rd, 1'b0);
    stream(n_sent, 200, 0, 0, 1'b1);

    check(order_bad == 0, "R8 order and values", order_bad, 0);
    check(n_recv == n_sent && n_sent == 328, "R8 count", n_recv, n_sent);
    tick(3);
    check(out_req == 1'b0 && in_ack == 1'b0, "R8 no extra word", out_req, 0);
    check(overlap_bad == 0, "R6 no overlap", overlap_bad, 0);
    check(stable_bad == 0, "R4 data stable while offered", stable_bad, 0);

    done = 1'b1;
    summary();
  end

endmodule